// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block merges the interrupt requests of a serial port into one interrupt line and tells software which cause to service first. Four causes arrive as level conditions that their own logic keeps asserted until serviced: a receive line error, the receive FIFO at or above its trigger level, a character timeout (unread data waiting too long in the receive FIFO), and a modem status change. The fifth cause, transmit FIFO empty, arrives as a one-cycle event. The controller holds it in a flag of its own, because its clearing depends on how the processor services it.

Every cause is gated by its own bit in an enable register. The controller then picks the most urgent of the enabled, pending causes and reports it in an identification register. The order, from most to least urgent, is line error, trigger level, timeout, transmit empty, modem change. Trigger level and timeout share a level, and trigger level is chosen when both are present. The identification register always reflects the current state, so once the reported cause is cleared it shows the next pending one. Software reaches both registers through a small register port with one address bit.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the enable register is all zeros. With every request active, `irq` is 0, the identification register reads 0x01 and the enable register reads 0x00.
- R2: A write with `reg_addr`=0 loads `reg_wdata` into the enable register. The bits are: bit0 line error, bit1 trigger level, bit2 timeout, bit3 transmit empty, bit4 modem change. The new value gates requests from the cycle after the write, and a read at address 0 returns it in `reg_rdata[4:0]` with the upper bits zero.
- R3: A request whose enable bit is 0 affects neither `irq` nor the identification register.
- R4: Among the enabled, pending requests, the identification register reports the most urgent one. The order is line error, trigger level, timeout, transmit empty, modem change.
- R5: At address 1, `reg_rdata[0]` is 0 when a cause is pending and 1 when none is. `reg_rdata[3:1]` holds the cause code, and `reg_rdata[7:4]` is zero. The cause codes are line error 011, trigger level 010, timeout 110, transmit empty 001 and modem change 000. With nothing pending the register reads 0x01.
- R6: `irq` is 1 exactly when at least one enabled request is pending.
- R7: A pulse on `tx_empty_set` sets the transmit-empty flag at the next clock edge. The flag stays set until one of the clear conditions in R8 or R9 occurs.
- R8: A read at address 1 clears the transmit-empty flag only while the register reports transmit empty. A read while it reports another cause leaves the flag set.
- R9: A pulse on `tx_data_wr` clears the transmit-empty flag.
- R10: If `tx_empty_set` arrives in the same cycle as a clear condition, the flag ends up set.
- R11: A write with `reg_addr`=1 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_err | input | 1 | Receive line error pending (level) |
| rx_trig | input | 1 | Receive FIFO at or above trigger level (level) |
| rx_tmo | input | 1 | Character timeout pending (level) |
| modem_chg | input | 1 | Modem status changed (level) |
| tx_empty_set | input | 1 | Transmit FIFO became empty (one-cycle event) |
| tx_data_wr | input | 1 | Processor wrote transmit data (strobe) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 enable register, 1 identification register |
| reg_wdata | input | 5 | Write data for the enable register |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Combined interrupt output |

## Verification
Directed sequences first raise each cause alone, so that every cause code is tried separately. They then stack causes in descending order, which shows that the arbitration is an ordered choice and not a merge of the requests. A partial enable mask with higher causes held high tells gating apart from arbitration. The transmit-empty flag is driven through read-clear, write-clear, a read while another cause is reported, and a set colliding with a clear. Seeded random cycles then mix all inputs and register traffic against a reference model, which covers orderings that the directed part never reaches.

// File: rtl/irq_ctrl_pkg.sv
// Package irq_ctrl_pkg
// Holds the source count, the source index map and the cause codes that the
// identification register reports. Index 0 is the most urgent source.
package irq_ctrl_pkg;
    localparam int N_SRC = 5;
    localparam int ID_W  = 3;

    localparam int SRC_ERR = 0;
    localparam int SRC_TRG = 1;
    localparam int SRC_TMO = 2;
    localparam int SRC_TXE = 3;
    localparam int SRC_MDM = 4;

    typedef enum logic [ID_W-1:0] {
        ID_MDM = 3'b000,
        ID_TXE = 3'b001,
        ID_TRG = 3'b010,
        ID_ERR = 3'b011,
        ID_TMO = 3'b110
    } irq_id_e;

    // Maps a source index to the code reported for it.
    function automatic irq_id_e src_code(input int idx);
        case (idx)
            SRC_ERR: return ID_ERR;
            SRC_TRG: return ID_TRG;
            SRC_TMO: return ID_TMO;
            SRC_TXE: return ID_TXE;
            default: return ID_MDM;
        endcase
    endfunction
endpackage

// File: rtl/irq_en_reg.sv
// Module irq_en_reg
// Enable mask register with one bit per interrupt source. It assumes that
// the write strobe is already qualified with the enable address.
module irq_en_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);
    // Purpose: clear the mask on reset, otherwise load it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end
endmodule

// File: rtl/irq_txe_flag.sv
// Module irq_txe_flag
// Holds the transmit-empty request between a set event and its servicing.
// It assumes that the set and clear inputs are single-cycle strobes. A set
// in the same cycle as a clear wins, so that a fresh event is never lost.
module irq_txe_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    // Purpose: set has priority over clear, and the flag holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module irq_prio_enc
// Gates the requests with the enable mask and picks the lowest-index
// (most urgent) active source. It reports the source's code, or a set
// none-pending flag when no enabled request is active. Purely combinational.
module irq_prio_enc
    import irq_ctrl_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    en,
    output logic            none_pend,
    output logic [ID_W-1:0] id_code
);
    logic [N-1:0] gated;

    // Purpose: mask the requests and choose the winner. The loop runs from the
    // least urgent source upward, so the most urgent active source is written last.
    always_comb begin
        gated     = req & en;
        none_pend = 1'b1;
        id_code   = ID_MDM;
        for (int i = N - 1; i >= 0; i--) begin
            if (gated[i]) begin
                none_pend = 1'b0;
                id_code   = src_code(i);
            end
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module uart_irq_ctrl
// Top level of the interrupt controller. It collects the level requests from
// the receive and modem logic and the transmit-empty event, then masks and
// arbitrates them. It exposes the enable and identification registers through
// a one-address-bit register port. It assumes that the level sources are
// cleared by their own logic and that all inputs are synchronous to clk.
module uart_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_err,
    input  logic              rx_trig,
    input  logic              rx_tmo,
    input  logic              modem_chg,
    input  logic              tx_empty_set,
    input  logic              tx_data_wr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic ADDR_EN = 1'b0;
    localparam logic ADDR_ID = 1'b1;
    localparam int   ID_PAD  = DATA_W - ID_W - 1;
    localparam int   EN_PAD  = DATA_W - N_SRC;

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] req_vec;
    logic             txe_q;
    logic             txe_clr;
    logic             none_pend;
    logic [ID_W-1:0]  id_code;

    irq_en_reg #(.W(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && (reg_addr == ADDR_EN)),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    // Purpose: a read that reports transmit empty services it, as does new transmit data.
    always_comb begin
        txe_clr = tx_data_wr ||
                  (reg_rd && (reg_addr == ADDR_ID) && !none_pend && (id_code == ID_TXE));
    end

    irq_txe_flag u_txe (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (tx_empty_set),
        .clr    (txe_clr),
        .flag_q (txe_q)
    );

    // Purpose: place each request at its priority index.
    always_comb begin
        req_vec          = '0;
        req_vec[SRC_ERR] = line_err;
        req_vec[SRC_TRG] = rx_trig;
        req_vec[SRC_TMO] = rx_tmo;
        req_vec[SRC_TXE] = txe_q;
        req_vec[SRC_MDM] = modem_chg;
    end

    irq_prio_enc #(.N(N_SRC)) u_enc (
        .req       (req_vec),
        .en        (en_q),
        .none_pend (none_pend),
        .id_code   (id_code)
    );

    // Purpose: combined interrupt output, any enabled request pending.
    always_comb begin
        irq = |(req_vec & en_q);
    end

    // Purpose: read data mux for the two registers.
    always_comb begin
        if (reg_addr == ADDR_ID) reg_rdata = {{ID_PAD{1'b0}}, id_code, none_pend};
        else                     reg_rdata = {{EN_PAD{1'b0}}, en_q};
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Module uart_irq_ctrl_chk
// Assertion checker for uart_irq_ctrl. It is attached to every instance of
// the top module by the bind statement at the end of this file.
module uart_irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             line_err,
    input logic             tx_empty_set,
    input logic             tx_data_wr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             reg_addr,
    input logic             irq,
    input logic [N_SRC-1:0] en_q,
    input logic             txe_q,
    input logic             none_pend,
    input logic [ID_W-1:0]  id_code
);
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_q == '0) && !irq && none_pend);

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    assert_error_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && en_q[SRC_ERR]) |-> (!none_pend && id_code == ID_ERR));

    assert_irq_vs_ident_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !none_pend);

    assert_txe_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_set |=> txe_q);

    assert_txe_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && !none_pend && id_code == ID_TXE && !tx_empty_set)
        |=> !txe_q);

    assert_txe_read_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && txe_q && id_code != ID_TXE && !tx_empty_set && !tx_data_wr)
        |=> txe_q);

    assert_txe_write_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_wr && !tx_empty_set) |=> !txe_q);

    assert_id_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> $stable(en_q));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_err     (line_err),
    .tx_empty_set (tx_empty_set),
    .tx_data_wr   (tx_data_wr),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .irq          (irq),
    .en_q         (en_q),
    .txe_q        (txe_q),
    .none_pend    (none_pend),
    .id_code      (id_code)
);

// File: tb/tb_uart_irq_ctrl.sv
// Bench for uart_irq_ctrl: directed corner cases followed by seeded random
// cycles. Every cycle is compared against a reference model kept in the bench.
module tb_uart_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 1500;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_err, rx_trig, rx_tmo, modem_chg;
    logic       tx_empty_set, tx_data_wr;
    logic       reg_wr, reg_rd, reg_addr;
    logic [4:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [4:0] m_en;
    logic       m_txe;

    uart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_trig(rx_trig),
        .rx_tmo(rx_tmo), .modem_chg(modem_chg), .tx_empty_set(tx_empty_set),
        .tx_data_wr(tx_data_wr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected identification nibble {code, none_pend} from the requirement table.
    function automatic logic [3:0] exp_ident(input logic [4:0] en, input logic err,
            input logic trg, input logic tmo, input logic txe, input logic mdm);
        if (err && en[0])      return {3'b011, 1'b0};
        else if (trg && en[1]) return {3'b010, 1'b0};
        else if (tmo && en[2]) return {3'b110, 1'b0};
        else if (txe && en[3]) return {3'b001, 1'b0};
        else if (mdm && en[4]) return {3'b000, 1'b0};
        else                   return 4'b0001;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        line_err = 0; rx_trig = 0; rx_tmo = 0; modem_chg = 0;
        tx_empty_set = 0; tx_data_wr = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = '0;
    endtask

    // Checks the outputs for the current inputs, then advances one clock and the model.
    task automatic cycle(input string tag);
        logic [3:0] id;
        logic [4:0] n_en;
        logic       n_txe;
        logic       exp_irq;
        #1;
        id      = exp_ident(m_en, line_err, rx_trig, rx_tmo, m_txe, modem_chg);
        exp_irq = !id[0];
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
        chk({tag, " rdata"}, reg_rdata, reg_addr ? {4'd0, id} : {3'd0, m_en});
        n_en  = (reg_wr && !reg_addr) ? reg_wdata : m_en;
        if (tx_empty_set) n_txe = 1'b1;
        else if (tx_data_wr || (reg_rd && reg_addr && id == 4'b0010)) n_txe = 1'b0;
        else n_txe = m_txe;
        @(posedge clk);
        @(negedge clk);
        m_en  = n_en;
        m_txe = n_txe;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        idle();
        rst_n = 1'b0;
        m_en = '0; m_txe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every request high, nothing enabled
        line_err = 1; rx_trig = 1; rx_tmo = 1; modem_chg = 1; reg_addr = 1;
        cycle("R1 ident");
        reg_addr = 0;
        cycle("R1 enable");

        // R2: write full mask, read it back
        idle(); line_err = 1; reg_wr = 1; reg_wdata = 5'h1F;
        cycle("R2 write");
        idle(); line_err = 1;
        cycle("R2 readback");
        // R11: write at the identification address is ignored
        idle(); reg_wr = 1; reg_addr = 1; reg_wdata = 5'h00;
        cycle("R11 write");
        idle();
        cycle("R11 mask kept");

        // R5: each cause alone
        idle(); reg_addr = 1; line_err = 1;  cycle("R5 error");
        idle(); reg_addr = 1; rx_trig = 1;   cycle("R5 trigger");
        idle(); reg_addr = 1; rx_tmo = 1;    cycle("R5 timeout");
        idle(); reg_addr = 1; modem_chg = 1; cycle("R5 modem");
        idle(); reg_addr = 1; tx_empty_set = 1; cycle("R7 set");
        idle(); reg_addr = 1; cycle("R7 held");
        idle(); reg_addr = 1; cycle("R7 held again");
        idle(); reg_addr = 1; modem_chg = 1; cycle("R4 txe over modem");
        idle(); reg_addr = 1; modem_chg = 1; reg_rd = 1; cycle("R8 read clear");
        idle(); reg_addr = 1; modem_chg = 1; cycle("R8 modem next");

        // R4: stacked causes
        idle(); reg_addr = 1; line_err = 1; rx_trig = 1; rx_tmo = 1; modem_chg = 1;
        cycle("R4 error wins");
        idle(); reg_addr = 1; rx_trig = 1; rx_tmo = 1; cycle("R4 trigger over timeout");
        idle(); reg_addr = 1; rx_tmo = 1; modem_chg = 1; cycle("R4 timeout over modem");

        // R8: read while another cause is shown keeps the flag
        idle(); tx_empty_set = 1; cycle("R7 set again");
        idle(); reg_addr = 1; line_err = 1; reg_rd = 1; cycle("R8 read other");
        idle(); reg_addr = 1; cycle("R8 flag kept");
        // R9: transmit write clears
        idle(); reg_addr = 1; tx_data_wr = 1; cycle("R9 write");
        idle(); reg_addr = 1; cycle("R9 cleared");
        // R10: set collides with both clears
        idle(); tx_empty_set = 1; cycle("R10 prep");
        idle(); reg_addr = 1; reg_rd = 1; tx_data_wr = 1; tx_empty_set = 1;
        cycle("R10 collide");
        idle(); reg_addr = 1; cycle("R10 still set");

        // R3: mask only the modem source
        idle(); reg_wr = 1; reg_wdata = 5'b10000; cycle("R3 mask write");
        idle(); reg_addr = 1; line_err = 1; rx_trig = 1; rx_tmo = 1; cycle("R3 masked");
        idle(); reg_addr = 1; line_err = 1; modem_chg = 1; cycle("R3 modem only");

        // Random mix for R4 R6 and the flag rules
        for (int i = 0; i < N_RAND; i++) begin
            idle();
            line_err     = ($urandom % 4) == 0;
            rx_trig      = ($urandom % 3) == 0;
            rx_tmo       = ($urandom % 3) == 0;
            modem_chg    = ($urandom % 2) == 0;
            tx_empty_set = ($urandom % 6) == 0;
            tx_data_wr   = ($urandom % 8) == 0;
            reg_addr     = $urandom % 2;
            reg_rd       = $urandom % 2;
            reg_wr       = ($urandom % 8) == 0;
            reg_wdata    = 5'($urandom);
            cycle("R4 R6 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule